// File: doc/BRIEF.md
# Four-bit subtract-and-branch processor core

This block is a self-contained 4-bit computer with a single instruction. It holds a 16-word by 4-bit working memory, a program counter, an operand address register, a subtracting ALU with two operand latches, a six-phase sequencer and an output register that shadows the top memory word. Each instruction takes three consecutive memory words, called here the source word, the target word and the jump word. The core subtracts the word the source points at from the word the target points at and writes the difference back to the target location. It then jumps to the jump address if the difference is zero or negative; otherwise it continues with the next instruction.

At reset the memory is loaded with a small looping program, so the output register counts up by one on every pass of the loop. The only external inputs are the clock and the reset. The program counter and the operand address register are brought out so that a debug display or a test harness can watch execution.

Top module: `sq4_core`

## Requirements
- R1: One instruction computes Mem[T] = (Mem[T] - Mem[S]) mod 16, where S and T are the words at PC and PC+1.
- R2: When that 4-bit result is zero or has bit 3 set, the next PC is the word at PC+2, read after the write.
- R3: When the result is positive (nonzero, bit 3 clear), the next PC is PC+3 modulo 16.
- R4: Every instruction takes exactly six clock cycles. PC changes only in the second, fifth and sixth cycles. After the instruction, `dbg_mar` holds the target address T.
- R5: A write to address 0xF also loads `out_port` with the written value. `out_port` changes on no other event.
- R6: Reset loads memory words 0..15 with 0,1,3, 1,0,6, 0,F,9, 0,0,3, 0,0,0, 0. As a result, the first instruction falls through to PC=3.
- R7: While `rst_n` is low, `out_port`, `dbg_pc` and `dbg_mar` are zero. Assertion takes effect asynchronously. After release, the first instruction cycle is the third rising edge.
- R8: The output first changes, to 1, on the 17th instruction-cycle edge after reset. It then steps by +1 modulo 16 exactly every 18 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| out_port | output | 4 | Output register shadowing memory word 0xF |
| dbg_pc | output | 4 | Program counter, for debug |
| dbg_mar | output | 4 | Operand address register, for debug |

## Verification
Two events can fall in the same cycle. The fifth phase writes the difference to memory, and that write may also load the output register. The sixth phase then chooses the branch from the same difference and reads the jump word, possibly just after it was written. A bench instruction-set model runs in step with the core. At every six-cycle instruction boundary it checks that PC, the operand address and the output all agree with the model, which covers taken and not-taken branches as well as output writes. Reset is also reasserted at random points in the middle of an instruction. The bench checks that the core returns to zero and that the first output step then occurs at the same fixed cycle.

// File: rtl/sq4_pkg.sv
package sq4_pkg;

  typedef enum logic [2:0] {
    PH_T0 = 3'd0,
    PH_T1 = 3'd1,
    PH_T2 = 3'd2,
    PH_T3 = 3'd3,
    PH_T4 = 3'd4,
    PH_T5 = 3'd5
  } phase_e;

  // Power-up program: counts the top word upward forever.
  function automatic logic [7:0] boot_word(input int unsigned idx);
    logic [7:0] w;
    case (idx)
      1:       w = 8'h1;
      2:       w = 8'h3;
      3:       w = 8'h1;
      5:       w = 8'h6;
      7:       w = 8'hF;
      8:       w = 8'h9;
      11:      w = 8'h3;
      default: w = 8'h0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/sq4_rstsync.sv
module sq4_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ni = sync_q[STAGES-1];
endmodule

// File: rtl/sq4_seq.sv
module sq4_seq
  import sq4_pkg::*;
(
  input  logic   clk,
  input  logic   rst_ni,
  output phase_e phase
);
  phase_e ph_q, ph_d;

  always_comb begin
    case (ph_q)
      PH_T0:   ph_d = PH_T1;
      PH_T1:   ph_d = PH_T2;
      PH_T2:   ph_d = PH_T3;
      PH_T3:   ph_d = PH_T4;
      PH_T4:   ph_d = PH_T5;
      default: ph_d = PH_T0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_T0;
    else         ph_q <= ph_d;
  end

  assign phase = ph_q;

  assert_phase_ring_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (ph_q == PH_T5) |=> (ph_q == PH_T0))
    else $error("phase did not return to T0");
endmodule

// File: rtl/sq4_alu.sv
module sq4_alu #(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          ld_a,
  input  logic          ld_b,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] res,
  output logic          leq
);
  logic [DW-1:0] a_q, b_q, a_d, b_d;

  always_comb begin
    a_d = ld_a ? din : a_q;
    b_d = ld_b ? din : b_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign res = b_q - a_q;
  assign leq = (res == '0) || res[DW-1];

  assert_src_hold_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    !ld_a |=> $stable(a_q))
    else $error("source latch changed without load");
endmodule

// File: rtl/sq4_mem.sv
module sq4_mem
  import sq4_pkg::*;
#(
  parameter int unsigned DW = 4,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_pc,
  output logic [DW-1:0] rd_pc,
  input  logic [AW-1:0] ra_mar,
  output logic [DW-1:0] rd_mar,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] out_q
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [AW-1:0] IO_ADDR = '1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] out_d;
  logic          io_wr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic hit;
    assign hit = we && (wa == AW'(i));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  mem_q[i] <= DW'(boot_word(i));
      else if (hit) mem_q[i] <= wd;
    end
  end

  assign rd_pc  = mem_q[ra_pc];
  assign rd_mar = mem_q[ra_mar];

  assign io_wr = we && (wa == IO_ADDR);
  assign out_d = io_wr ? wd : out_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  assert_io_shadow_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    io_wr |=> (out_q == $past(wd)) && (mem_q[IO_ADDR] == out_q))
    else $error("output register missed a top-word write");

  assert_io_hold_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    !io_wr |=> $stable(out_q))
    else $error("output register changed without a top-word write");
endmodule

// File: rtl/sq4_core.sv
module sq4_core
  import sq4_pkg::*;
#(
  parameter int unsigned DW = 4,
  parameter int unsigned AW = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] out_port,
  output logic [AW-1:0] dbg_pc,
  output logic [AW-1:0] dbg_mar
);
  logic          rst_ni;
  phase_e        phase;
  logic [AW-1:0] pc_q, pc_d, mar_q, mar_d;
  logic [DW-1:0] rd_pc, rd_mar, res;
  logic          leq, ld_a, ld_b, we;

  sq4_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ni(rst_ni));

  sq4_seq u_seq (.clk(clk), .rst_ni(rst_ni), .phase(phase));

  sq4_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .rst_ni(rst_ni),
    .ra_pc(pc_q), .rd_pc(rd_pc),
    .ra_mar(mar_q), .rd_mar(rd_mar),
    .we(we), .wa(mar_q), .wd(res),
    .out_q(out_port));

  sq4_alu #(.DW(DW)) u_alu (
    .clk(clk), .rst_ni(rst_ni),
    .ld_a(ld_a), .ld_b(ld_b), .din(rd_mar),
    .res(res), .leq(leq));

  assign ld_a = (phase == PH_T1);
  assign ld_b = (phase == PH_T3);
  assign we   = (phase == PH_T4);

  always_comb begin
    pc_d  = pc_q;
    mar_d = mar_q;
    case (phase)
      PH_T0, PH_T2: mar_d = AW'(rd_pc);
      PH_T1, PH_T4: pc_d  = pc_q + 1'b1;
      PH_T5:        pc_d  = leq ? AW'(rd_pc) : pc_q + 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
    end else begin
      pc_q  <= pc_d;
      mar_q <= mar_d;
    end
  end

  assign dbg_pc  = pc_q;
  assign dbg_mar = mar_q;

  assert_pc_hold_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == PH_T0 || phase == PH_T2 || phase == PH_T3) |=> $stable(pc_q))
    else $error("PC moved in a hold phase");

  assert_branch_taken_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == PH_T5 && leq) |=> (pc_q == $past(rd_pc)))
    else $error("taken branch did not load jump word");

  assert_fall_through_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == PH_T5 && !leq) |=> (pc_q == $past(pc_q) + 1'b1))
    else $error("positive result did not fall through");
endmodule

// File: tb/sq4_core_test.sv
module sq4_core_test;
  logic       clk;
  logic       rst_n;
  logic [3:0] out_port, dbg_pc, dbg_mar;

  sq4_core uut (.clk(clk), .rst_n(rst_n), .out_port(out_port),
                .dbg_pc(dbg_pc), .dbg_mar(dbg_mar));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [3:0] m [16];
  logic [3:0] m_pc, m_mar, m_out;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] image(input int i);
    case (i)
      1, 3:  return 4'h1;
      2, 11: return 4'h3;
      5:     return 4'h6;
      7:     return 4'hF;
      8:     return 4'h9;
      default: return 4'h0;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m[i] = image(i);
    m_pc = 0; m_mar = 0; m_out = 0;
  endtask

  // one instruction of the model; returns 1 if branch taken
  function automatic bit model_step();
    logic [3:0] a, b, r;
    a = m[m_pc];
    b = m[m_pc + 4'd1];
    r = m[b] - m[a];
    m[b] = r;
    if (b == 4'hF) m_out = r;
    m_mar = b;
    if (r == 0 || r[3]) begin
      m_pc = m[m_pc + 4'd2];
      return 1'b1;
    end
    m_pc = m_pc + 4'd3;
    return 1'b0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4021));
    rst_n = 1'b0;
    for (int run = 0; run < 4; run++) begin
      int n_edges, e, last_chg;
      logic [3:0] prev_out;
      bit taken;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(out_port == 0, "R7 out async", out_port, 0);
      chk(dbg_pc == 0 && dbg_mar == 0, "R7 pc/mar async", {dbg_pc, dbg_mar}, 0);
      repeat (1 + $urandom % 3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      n_edges = 300 + $urandom % 700;
      last_chg = -1;
      prev_out = 4'h0;
      for (e = 1; e <= n_edges; e++) begin
        @(negedge clk);
        if (e == 18) chk(out_port == 0, "R8 no early step", out_port, 0);
        if (e == 19) chk(out_port == 1, "R8 first step", out_port, 1);
        if (out_port != prev_out) begin
          if (last_chg < 0) chk(e == 19, "R8 first step edge", e, 19);
          else chk(e - last_chg == 18, "R8 step spacing", e - last_chg, 18);
          chk(out_port == prev_out + 4'd1, "R8 step by one", out_port, prev_out + 4'd1);
          last_chg = e;
          prev_out = out_port;
        end
        if (e >= 8 && (e - 8) % 6 == 0) begin
          taken = model_step();
          if (e == 8) chk(dbg_pc == 4'h3, "R6 boot image first pc", dbg_pc, 3);
          if (taken) chk(dbg_pc == m_pc, "R2 branch pc", dbg_pc, m_pc);
          else       chk(dbg_pc == m_pc, "R3 fall-through pc", dbg_pc, m_pc);
          chk(dbg_mar == m_mar, "R4 mar holds target", dbg_mar, m_mar);
          chk(out_port == m_out, "R1/R5 output value", out_port, m_out);
        end else if (e < 3) begin
          chk(dbg_pc == 0 && dbg_mar == 0, "R7 idle during sync", {dbg_pc, dbg_mar}, 0);
        end
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule